// File: doc/BRIEF.md
# Serial Flash Read Front-End

This block is the serial slave side of a 1 Mbit serial flash, limited to read traffic. A host drives chip select low, shifts in an 8-bit instruction and a 24-bit address on the serial clock, and then clocks data bytes back out. Two instructions are understood. The plain read returns data right after the address. The fast read first consumes eight dummy clocks. Any other instruction leaves the device silent until chip select rises again.

The serial pins are oversampled by the system clock through a synchronizer, and the serial clock edges are detected in the system clock domain. Serial clock mode 0 (idle low) and mode 3 (idle high) both work, because only rising edges capture input and only falling edges launch output. A hold pin freezes the transfer in mid-byte and floats the data output. The storage behind the front-end is a computed pattern array, so every byte value can be predicted from its address. The address counter covers 17 bits and returns to zero after the last byte.

Top module: `spi_flash_rd`

## Requirements
- R1: The output enable `so_oe` is low whenever chip select is high (within four system clocks after it rises) and through the instruction, address and dummy phases of a frame.
- R2: Opcode 03h is followed by 24 address bits, MSB first, captured on rising serial clock edges. Data then leaves on `so` MSB first, each bit updated after a falling edge. The byte at address a equals a[7:0] XOR a[15:8] XOR {7'b0, a[16]} XOR 8'h3C.
- R3: Opcode 0Bh behaves like 03h, except that eight serial clocks after the address are discarded before the first data bit is launched.
- R4: Address bits 23 down to 17 have no effect on which byte is returned.
- R5: After each byte the address steps by one. After address 1FFFFh, the next byte comes from address 00000h within the same frame.
- R6: With the serial clock idling high (mode 3), reads return the same data as in mode 0.
- R7: While chip select is low, hold low with the serial clock low pauses the transfer and forces `so_oe` low. Clock and data toggles during the pause are ignored. After release with the clock low, the paused bit is presented again and the byte completes with no bit lost or added.
- R8: Raising chip select during data output ends the read. The next frame decodes a fresh opcode and address.
- R9: A frame whose opcode is neither 03h nor 0Bh keeps `so_oe` low for the rest of that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Chip select, active low |
| si | input | 1 | Serial data in (instruction, address, dummy) |
| hold_n | input | 1 | Pause request, active low |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Drive enable for `so`; low means high impedance |

## Verification
The bench runs a fast read that starts two bytes below the top of the array. A counter that saturates, or one that carries into the ignored upper bits, would return the wrong third byte. Another read sets all the don't-care address bits. A design that kept even one of them would read from the wrong place. A hold is entered in mid-byte, the clock and data are toggled under it, and then it is released. A design that counted those edges, or dropped the paused bit, would return a shifted byte. The bench also sends an unknown opcode followed by many more clocks, and aborts a read after three bits. A decoder that fell back into a read, or kept a stale bit counter into the next frame, would drive the output or misalign the next byte.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;

    // Instruction codes accepted by the front-end
    localparam logic [7:0] OPC_READ = 8'h03;
    localparam logic [7:0] OPC_FAST = 8'h0B;

    // Frame phases; ST_OPC must stay at zero (reset value)
    typedef enum logic [2:0] {
        ST_OPC   = 3'd0,
        ST_ADDR  = 3'd1,
        ST_DUMMY = 3'd2,
        ST_DATA  = 3'd3,
        ST_IGN   = 3'd4
    } rd_state_e;

endpackage

// File: rtl/spi_rd_sync.sv
module spi_rd_sync #(
    parameter int             W      = 4,
    parameter int             STAGES = 2,
    parameter logic [W-1:0]   RST    = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stage_q [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        logic [W-1:0] stage_d;
        if (i == 0) begin : g_first
            assign stage_d = din;
        end else begin : g_next
            assign stage_d = stage_q[i-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[i] <= RST;
            else        stage_q[i] <= stage_d;
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/spi_rd_pattern.sv
module spi_rd_pattern #(
    parameter int            AW   = 17,
    parameter int            DW   = 8,
    parameter logic [DW-1:0] SEED = 8'h3C
) (
    input  logic [AW-1:0] addr,
    output logic [DW-1:0] data
);

    localparam int NCH = (AW + DW - 1) / DW;
    localparam int PW  = NCH * DW;

    logic [PW-1:0] padded;
    assign padded = PW'(addr);

    // Each byte lane of the address folds into the seed value
    always_comb begin
        data = SEED;
        for (int i = 0; i < NCH; i++) begin
            data = data ^ padded[i*DW +: DW];
        end
    end

endmodule

// File: rtl/spi_rd_ctrl.sv
module spi_rd_ctrl
    import spi_rd_pkg::*;
#(
    parameter int AW = 17,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sck,
    input  logic          desel,
    input  logic          mosi,
    input  logic          hold_n,
    input  logic [DW-1:0] rdata,
    output logic [AW-1:0] rd_addr,
    output logic          miso_o,
    output logic          oe_o,
    output logic          hold_o,
    output rd_state_e     st_o
);

    localparam int SRW      = AW - 1;
    localparam int CW       = 5;
    localparam int BW       = $clog2(DW);
    localparam int OPC_BITS = 8;
    localparam int ADR_BITS = 24;
    localparam int DMY_BITS = 8;

    typedef struct packed {
        rd_state_e        st;
        logic [CW-1:0]    cnt;
        logic [SRW-1:0]   sr;
        logic             fast;
        logic [AW-1:0]    addr;
        logic             sck_prev;
        logic             hold;
        logic             miso;
        logic             oe;
    } ctrl_s;

    ctrl_s q, d;

    logic          rise, fall;
    logic [AW-1:0] full;

    always_comb begin
        d    = q;
        rise = sck & ~q.sck_prev;
        fall = ~sck & q.sck_prev;
        full = {q.sr, mosi};
        d.sck_prev = sck;

        if (desel) begin
            d.st   = ST_OPC;
            d.cnt  = '0;
            d.oe   = 1'b0;
            d.hold = 1'b0;
        end else begin
            // pause entry and exit only with the serial clock low
            if (!q.hold && !hold_n && !sck)     d.hold = 1'b1;
            else if (q.hold && hold_n && !sck)  d.hold = 1'b0;

            if (!q.hold && rise) begin
                case (q.st)
                    ST_OPC: begin
                        d.sr = {q.sr[SRW-2:0], mosi};
                        if (q.cnt == CW'(OPC_BITS - 1)) begin
                            d.cnt = '0;
                            if (full[7:0] == OPC_READ) begin
                                d.st   = ST_ADDR;
                                d.fast = 1'b0;
                            end else if (full[7:0] == OPC_FAST) begin
                                d.st   = ST_ADDR;
                                d.fast = 1'b1;
                            end else begin
                                d.st   = ST_IGN;
                            end
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                    ST_ADDR: begin
                        d.sr = {q.sr[SRW-2:0], mosi};
                        if (q.cnt == CW'(ADR_BITS - 1)) begin
                            d.cnt  = '0;
                            d.addr = full;
                            d.st   = q.fast ? ST_DUMMY : ST_DATA;
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                    ST_DUMMY: begin
                        if (q.cnt == CW'(DMY_BITS - 1)) begin
                            d.cnt = '0;
                            d.st  = ST_DATA;
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end

            if (!q.hold && fall && q.st == ST_DATA) begin
                d.miso = rdata[BW'(DW - 1) - q.cnt[BW-1:0]];
                d.oe   = 1'b1;
                if (q.cnt[BW-1:0] == BW'(DW - 1)) begin
                    d.cnt  = '0;
                    d.addr = q.addr + 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_addr = q.addr;
    assign miso_o  = q.miso;
    assign oe_o    = q.oe & ~q.hold;
    assign hold_o  = q.hold;
    assign st_o    = q.st;

endmodule

// File: rtl/spi_flash_rd.sv
module spi_flash_rd
    import spi_rd_pkg::*;
#(
    parameter int AW          = 17,
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic si,
    input  logic hold_n,
    output logic so,
    output logic so_oe
);

    localparam int NPIN = 4;
    // pin order {sck, cs_n, si, hold_n}; idle: clock low, deselected, hold released
    localparam logic [NPIN-1:0] PIN_RST = 4'b0101;

    logic [NPIN-1:0] pins_s;
    logic            sck_s, cs_s, si_s, hold_s;
    logic [AW-1:0]   rd_addr;
    logic [DW-1:0]   rdata;
    logic            hold_act;
    rd_state_e       st;

    spi_rd_sync #(
        .W      (NPIN),
        .STAGES (SYNC_STAGES),
        .RST    (PIN_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({sck, cs_n, si, hold_n}),
        .dout  (pins_s)
    );

    assign {sck_s, cs_s, si_s, hold_s} = pins_s;

    spi_rd_pattern #(
        .AW (AW),
        .DW (DW)
    ) u_array (
        .addr (rd_addr),
        .data (rdata)
    );

    spi_rd_ctrl #(
        .AW (AW),
        .DW (DW)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck     (sck_s),
        .desel   (cs_s),
        .mosi    (si_s),
        .hold_n  (hold_s),
        .rdata   (rdata),
        .rd_addr (rd_addr),
        .miso_o  (so),
        .oe_o    (so_oe),
        .hold_o  (hold_act),
        .st_o    (st)
    );

endmodule

// File: rtl/spi_flash_rd_chk.sv
module spi_flash_rd_chk
    import spi_rd_pkg::*;
#(
    parameter int AW = 17
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_s,
    input logic          sck_s,
    input logic          so,
    input logic          so_oe,
    input logic          hold_act,
    input rd_state_e     st,
    input logic [AW-1:0] rd_addr
);

    p_deselect_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !so_oe)
        else $error("R1: output enabled after deselect");

    p_no_drive_outside_data_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_DATA) |-> !so_oe)
        else $error("R1: output enabled outside data phase");

    p_launch_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(so) |-> (!$past(sck_s) && $past(sck_s, 2)))
        else $error("R2: output moved without a falling clock edge");

    p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DATA && $past(st) == ST_DATA && rd_addr != $past(rd_addr))
            |-> (rd_addr == AW'($past(rd_addr) + 1'b1)))
        else $error("R5: address did not step by one");

    p_hold_tristate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hold_act |-> !so_oe)
        else $error("R7: output driven during hold");

    p_ignore_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IGN) |-> !so_oe)
        else $error("R9: output driven after unknown opcode");

endmodule

bind spi_flash_rd spi_flash_rd_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_s     (cs_s),
    .sck_s    (sck_s),
    .so       (so),
    .so_oe    (so_oe),
    .hold_act (hold_act),
    .st       (st),
    .rd_addr  (rd_addr)
);

// File: tb/spi_flash_rd_bench.sv
`timescale 1ns/1ps
module spi_flash_rd_bench;

    localparam int H = 8;   // system clocks per serial half period

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0;
    logic cs_n = 1'b1;
    logic si = 1'b0;
    logic hold_n = 1'b1;
    logic so, so_oe;
    logic mode3 = 1'b0;

    int  n_chk  = 0;
    int  n_bad  = 0;
    bit  done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    spi_flash_rd u_spi_flash_rd (
        .clk    (clk),
        .rst_n  (rst_n),
        .sck    (sck),
        .cs_n   (cs_n),
        .si     (si),
        .hold_n (hold_n),
        .so     (so),
        .so_oe  (so_oe)
    );

    function automatic logic [7:0] pat(input logic [16:0] a);
        return a[7:0] ^ a[15:8] ^ {7'b0, a[16]} ^ 8'h3C;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic frame_start();
        sck = mode3; tick(H);
        cs_n = 1'b0; tick(H);
    endtask

    task automatic frame_end();
        sck = mode3; tick(H);
        cs_n = 1'b1; tick(2*H);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sck = 1'b0; si = b[i]; tick(H);
            sck = 1'b1; tick(H);
        end
    endtask

    task automatic recv_byte(output logic [7:0] b, output logic oe_all, output logic oe_any);
        b = '0; oe_all = 1'b1; oe_any = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            sck = 1'b0; tick(H);
            b[i] = so; oe_all &= so_oe; oe_any |= so_oe;
            sck = 1'b1; tick(H);
        end
    endtask

    task automatic send_cmd(input logic [7:0] opc, input logic [23:0] a);
        send_byte(opc);
        send_byte(a[23:16]); send_byte(a[15:8]); send_byte(a[7:0]);
    endtask

    task automatic read_expect(input string req, input logic [16:0] start, input int n);
        logic [7:0] b;
        logic oa, oy;
        for (int k = 0; k < n; k++) begin
            logic [16:0] ea;
            ea = start + 17'(k);
            recv_byte(b, oa, oy);
            chk(b == pat(ea), req, {24'h0, b}, {24'h0, pat(ea)});
            chk(oa, {req, " oe"}, {31'h0, oa}, 32'h1);
        end
    endtask

    task automatic t_reset();
        chk(so_oe == 1'b0, "R1 reset", {31'h0, so_oe}, 32'h0);
    endtask

    task automatic t_read_basic();   // R2, R5 increment, R1 during address
        mode3 = 1'b0;
        frame_start();
        send_cmd(8'h03, 24'h000100);
        chk(so_oe == 1'b0, "R1 address phase", {31'h0, so_oe}, 32'h0);
        read_expect("R2 read", 17'h00100, 4);
        frame_end();
        chk(so_oe == 1'b0, "R1 after deselect", {31'h0, so_oe}, 32'h0);
    endtask

    task automatic t_fast();          // R3
        logic [7:0] b;
        logic oa, oy;
        mode3 = 1'b0;
        frame_start();
        send_cmd(8'h0B, 24'h012345);
        send_byte(8'hA5);
        chk(so_oe == 1'b0, "R3 dummy quiet", {31'h0, so_oe}, 32'h0);
        recv_byte(b, oa, oy);
        chk(b == pat(17'h12345), "R3 first", {24'h0, b}, {24'h0, pat(17'h12345)});
        read_expect("R3 fast", 17'h12346, 2);
        frame_end();
    endtask

    task automatic t_upper_ignored(); // R4
        mode3 = 1'b0;
        frame_start();
        send_cmd(8'h03, 24'hFE0100);
        read_expect("R4 upper bits", 17'h00100, 2);
        frame_end();
    endtask

    task automatic t_wrap_mode3();    // R5 wrap, R6
        mode3 = 1'b1;
        frame_start();
        send_cmd(8'h0B, 24'h01FFFE);
        send_byte(8'h00);
        read_expect("R5 wrap", 17'h1FFFE, 3);
        frame_end();
    endtask

    task automatic t_mode3_read();    // R6
        mode3 = 1'b1;
        frame_start();
        send_cmd(8'h03, 24'h00ABCD);
        read_expect("R6 mode3", 17'h0ABCD, 2);
        frame_end();
        mode3 = 1'b0;
    endtask

    task automatic t_hold();          // R7
        logic [7:0] b, e;
        logic oa, oy;
        mode3 = 1'b0;
        frame_start();
        send_cmd(8'h03, 24'h000200);
        recv_byte(b, oa, oy);
        chk(b == pat(17'h200), "R7 byte0", {24'h0, b}, {24'h0, pat(17'h200)});
        e = pat(17'h201);
        b = '0;
        for (int i = 7; i >= 5; i--) begin
            sck = 1'b0; tick(H); b[i] = so;
            sck = 1'b1; tick(H);
        end
        hold_n = 1'b0; tick(H);
        sck = 1'b0; tick(H);
        chk(so_oe == 1'b0, "R7 hold tristate", {31'h0, so_oe}, 32'h0);
        for (int p = 0; p < 3; p++) begin
            si = ~si;
            sck = 1'b1; tick(H);
            sck = 1'b0; tick(H);
        end
        chk(so_oe == 1'b0, "R7 hold persists", {31'h0, so_oe}, 32'h0);
        hold_n = 1'b1; tick(H);
        chk(so_oe == 1'b1, "R7 resume oe", {31'h0, so_oe}, 32'h1);
        b[4] = so;
        sck = 1'b1; tick(H);
        for (int i = 3; i >= 0; i--) begin
            sck = 1'b0; tick(H); b[i] = so;
            sck = 1'b1; tick(H);
        end
        chk(b == e, "R7 byte across hold", {24'h0, b}, {24'h0, e});
        read_expect("R7 after hold", 17'h202, 1);
        frame_end();
    endtask

    task automatic t_abort();         // R8
        mode3 = 1'b0;
        frame_start();
        send_cmd(8'h03, 24'h000300);
        for (int i = 0; i < 3; i++) begin
            sck = 1'b0; tick(H);
            sck = 1'b1; tick(H);
        end
        cs_n = 1'b1; tick(H);
        chk(so_oe == 1'b0, "R8 abort oe", {31'h0, so_oe}, 32'h0);
        tick(H);
        frame_start();
        send_cmd(8'h03, 24'h000040);
        read_expect("R8 fresh frame", 17'h00040, 1);
        frame_end();
    endtask

    task automatic t_bad_opcode();    // R9
        logic [7:0] b;
        logic oa, oy;
        logic any = 1'b0;
        mode3 = 1'b0;
        frame_start();
        send_cmd(8'h9F, 24'h000000);
        for (int k = 0; k < 2; k++) begin
            recv_byte(b, oa, oy);
            any |= oy;
        end
        chk(any == 1'b0, "R9 silent frame", {31'h0, any}, 32'h0);
        frame_end();
        frame_start();
        send_cmd(8'h03, 24'h000055);
        read_expect("R9 recovery", 17'h00055, 1);
        frame_end();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        tick(4);
        rst_n = 1'b1;
        tick(4);
        t_reset();
        t_read_basic();
        t_fast();
        t_upper_ignored();
        t_wrap_mode3();
        t_mode3_read();
        t_hold();
        t_abort();
        t_bad_opcode();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule